// File: doc/BRIEF.md
# Cache-Side Performance Event Counter Unit

This block counts micro-architectural events produced by a shared cache. It holds eight counters. Each one carries an 8-bit event code that picks one line out of a 256-line vector of single-cycle event strobes. A counter adds one for every clock in which its chosen strobe is high. Two reserved codes have fixed meanings: one never counts and the other counts every clock. A global run bit starts and stops all counters at once. A per-counter enable mask chooses which counters take part.

Software programs and reads the unit through a plain register bus. Each access carries a write strobe, a 16-bit byte address and 64-bit write data, and read data comes back combinationally from the address. Counters are 64-bit registers. All other registers are 32 bits wide, use the low half of the data bus and read back zero-extended. When a counter wraps it sets an overflow status bit. Each status bit drives the interrupt output unless its mask bit is set. Status bits are cleared by writing 1 to them in a separate clear register. Each counter also has an 8-bit data-source selection byte that software can store and read back. The build-time counter width is 48 or 64 bits, and a read-only revision register tells software which width was built.

Top module: `pmon_unit`

## Requirements
- R1: Counter i is a 64-bit read/write register at byte address 0x1E00 + 8*i (i = 0..7). A write to it replaces the count.
- R2: In a 48-bit build (the default), counter bits 63:48 always read as zero and written values in those bits are dropped. A 64-bit build keeps all bits.
- R3: The read-only register at 0x1CF0 returns 0x30 in a 64-bit build and 0x21 in a 48-bit build. Writes to it have no effect.
- R4: Counter i takes its event code from byte lane i%4 (bits 8*(i%4)+7:8*(i%4)) of the register at 0x1D00 + 4*(i/4). It adds one at each clock edge where event strobe line number <code> is high while the counter is running.
- R5: Code 0xFF never counts, whatever the strobes do. Code 0x7F counts on every clock edge while the counter is running.
- R6: Bit 16 of the register at 0x0408 is the global run bit. While it is 0, no counter changes except by a software write.
- R7: Bit i of the register at 0x1C00 enables counter i. A counter with a 0 there holds its value even when the run bit is set.
- R8: When counter i rolls over from all ones of its width to zero, bit i of the status register at 0x0808 becomes 1 on the same edge. Writes to 0x0808 are ignored.
- R9: Writing 1 to bit i of 0x080C clears status bit i, and 0 bits leave status unchanged. The register reads as zero. A new overflow in the same cycle wins over the clear.
- R10: The register at 0x0800 holds one mask bit per counter (1 = masked). irq_o is high exactly when some status bit is 1 while its mask bit is 0.
- R11: Data-source bytes for counters 0-3 and 4-7 sit in 32-bit registers at 0x1B48 and 0x1B4C, with the same lane packing as event codes. They read back exactly as written.
- R12: A software write to a counter takes priority over an increment in the same cycle. The counter then holds exactly the written value.
- R13: After reset all counters are zero, the run bit, enable mask and status are zero, every mask bit is 1, every event code is 0xFF, every data-source byte is zero, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the addressed register is written at the next rising edge |
| bus_addr | input | 16 | Byte address of the register being accessed |
| bus_wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| bus_rdata | output | 64 | Combinational read data for bus_addr |
| evt_i | input | 256 | Event strobe vector, one line per event code |
| irq_o | output | 1 | Overflow interrupt, level-sensitive |

## Verification
Properties are checked on every cycle. A stopped or disabled counter, or one coded 0xFF, must hold its value unless software writes it. A written counter must hold exactly the written value on the next cycle. A rollover must leave its status bit set. A clear must drop the status bits it names. With every mask bit set, the interrupt must stay low. Only the directed scenarios can show the things that depend on the address map and the counting sequence. These are lane packing, exact counts for irregular strobe patterns, rollover at the 48-bit boundary, the upper bits reading as zero, and the revision value.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
    localparam int EVT_LINES = 256;
    localparam int CODE_W    = 8;

    localparam logic [15:0] A_CTRL   = 16'h0408;
    localparam logic [15:0] A_IMASK  = 16'h0800;
    localparam logic [15:0] A_ISTAT  = 16'h0808;
    localparam logic [15:0] A_ICLR   = 16'h080C;
    localparam logic [15:0] A_DSRC   = 16'h1B48;
    localparam logic [15:0] A_ENABLE = 16'h1C00;
    localparam logic [15:0] A_REV    = 16'h1CF0;
    localparam logic [15:0] A_CODE   = 16'h1D00;
    localparam logic [15:0] A_CNT    = 16'h1E00;

    localparam int RUN_BIT = 16;

    localparam logic [CODE_W-1:0] CODE_IDLE  = 8'hFF;
    localparam logic [CODE_W-1:0] CODE_CLOCK = 8'h7F;

    localparam logic [31:0] REV_WIDE   = 32'h0000_0030;
    localparam logic [31:0] REV_NARROW = 32'h0000_0021;
endpackage

// File: rtl/pmon_evsel.sv
module pmon_evsel
    import pmon_pkg::*;
#(
    parameter int NUM_EVT = EVT_LINES
) (
    input  logic [CODE_W-1:0]  code_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               hit_o
);
    always_comb begin
        if (code_i == CODE_IDLE) begin
            hit_o = 1'b0;
        end else if (code_i == CODE_CLOCK) begin
            hit_o = 1'b1;
        end else if (int'(code_i) < NUM_EVT) begin
            hit_o = evt_i[code_i];
        end else begin
            hit_o = 1'b0;
        end
    end
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_val_i,
    output logic [63:0]      val_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (wr_i) begin
            cnt_d = wr_val_i;
        end else if (inc_i) begin
            cnt_d  = cnt_q + 1'b1;
            wrap_o = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign val_o = 64'(cnt_q);

    // R12
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (val_o == 64'($past(wr_val_i))));

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !wr_i) |=> (val_o == 64'(CNT_W'($past(val_o) + 64'd1))));

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (val_o == 64'd0));
endmodule

// File: rtl/pmon_unit.sv
module pmon_unit
    import pmon_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [15:0]          bus_addr,
    input  logic [63:0]          bus_wdata,
    output logic [63:0]          bus_rdata,
    input  logic [EVT_LINES-1:0] evt_i,
    output logic                 irq_o
);
    localparam logic [31:0] REV_VAL = (CNT_W == 64) ? REV_WIDE : REV_NARROW;

    typedef struct packed {
        logic                           run;
        logic [NUM_CNT-1:0]             cnt_en;
        logic [NUM_CNT-1:0]             int_mask;
        logic [NUM_CNT-1:0]             int_stat;
        logic [NUM_CNT-1:0][CODE_W-1:0] code;
        logic [NUM_CNT-1:0][CODE_W-1:0] dsrc;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_CNT-1:0]       hit, inc, cnt_wr, wrap;
    logic [NUM_CNT-1:0][63:0] cnt_val;
    logic [NUM_CNT-1:0]       clr_vec;

    generate
        if (CNT_W < 64) begin : g_hi_unused
            logic unused_hi;
            assign unused_hi = ^bus_wdata[63:CNT_W];
        end
    endgenerate

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
        assign cnt_wr[i] = bus_wr && (bus_addr == 16'(A_CNT + 16'(8 * i)));
        assign inc[i]    = regs_q.run && regs_q.cnt_en[i] && hit[i];

        pmon_evsel #(.NUM_EVT(EVT_LINES)) u_sel (
            .code_i (regs_q.code[i]),
            .evt_i  (evt_i),
            .hit_o  (hit[i])
        );

        pmon_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (inc[i]),
            .wr_i     (cnt_wr[i]),
            .wr_val_i (bus_wdata[CNT_W-1:0]),
            .val_o    (cnt_val[i]),
            .wrap_o   (wrap[i])
        );

        // R5 R7
        hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((regs_q.code[i] == CODE_IDLE || !regs_q.cnt_en[i]) && !cnt_wr[i])
            |=> $stable(cnt_val[i]));
    end

    always_comb begin
        regs_d  = regs_q;
        clr_vec = '0;
        if (bus_wr) begin
            if (bus_addr == A_CTRL)   regs_d.run      = bus_wdata[RUN_BIT];
            if (bus_addr == A_ENABLE) regs_d.cnt_en   = bus_wdata[NUM_CNT-1:0];
            if (bus_addr == A_IMASK)  regs_d.int_mask = bus_wdata[NUM_CNT-1:0];
            if (bus_addr == A_ICLR)   clr_vec         = bus_wdata[NUM_CNT-1:0];
            for (int i = 0; i < NUM_CNT; i++) begin
                if (bus_addr == 16'(A_CODE + 16'(4 * (i / 4))))
                    regs_d.code[i] = bus_wdata[8 * (i % 4) +: 8];
                if (bus_addr == 16'(A_DSRC + 16'(4 * (i / 4))))
                    regs_d.dsrc[i] = bus_wdata[8 * (i % 4) +: 8];
            end
        end
        regs_d.int_stat = (regs_q.int_stat & ~clr_vec) | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.run      <= 1'b0;
            regs_q.cnt_en   <= '0;
            regs_q.int_mask <= '1;
            regs_q.int_stat <= '0;
            regs_q.code     <= '1;
            regs_q.dsrc     <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)   bus_rdata[RUN_BIT]       = regs_q.run;
        if (bus_addr == A_ENABLE) bus_rdata[NUM_CNT-1:0]   = regs_q.cnt_en;
        if (bus_addr == A_IMASK)  bus_rdata[NUM_CNT-1:0]   = regs_q.int_mask;
        if (bus_addr == A_ISTAT)  bus_rdata[NUM_CNT-1:0]   = regs_q.int_stat;
        if (bus_addr == A_REV)    bus_rdata[31:0]          = REV_VAL;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (bus_addr == 16'(A_CNT + 16'(8 * i)))
                bus_rdata = cnt_val[i];
            if (bus_addr == 16'(A_CODE + 16'(4 * (i / 4))))
                bus_rdata[8 * (i % 4) +: 8] = regs_q.code[i];
            if (bus_addr == 16'(A_DSRC + 16'(4 * (i / 4))))
                bus_rdata[8 * (i % 4) +: 8] = regs_q.dsrc[i];
        end
    end

    assign irq_o = |(regs_q.int_stat & ~regs_q.int_mask);

    // R6
    run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.run && cnt_wr == '0) |=> $stable(cnt_val));

    // R8
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> ((regs_q.int_stat & $past(wrap)) == $past(wrap)));

    // R9
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ICLR && wrap == '0)
        |=> ((regs_q.int_stat & $past(bus_wdata[NUM_CNT-1:0])) == '0));

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.int_mask == '1) |-> !irq_o);
endmodule

// File: tb/sim_pmon_unit.sv
module sim_pmon_unit;
    localparam int CW = 48;
    localparam logic [63:0] KEEP = (CW == 64) ? '1 : ((64'd1 << CW) - 64'd1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [63:0]  bus_wdata = '0;
    logic [63:0]  bus_rdata;
    logic [255:0] evt = '0;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pmon_unit #(.NUM_CNT(8), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_for(input int n);
        wr(16'h0408, 64'h1_0000);
        repeat (n - 1) @(posedge clk);
        wr(16'h0408, 64'h0);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(16'(16'h1E00 + 8 * i), v); chk("R13 counter", v, 64'h0);
        end
        rd(16'h0800, v); chk("R13 mask", v, 64'hFF);
        rd(16'h1D00, v); chk("R13 code0", v, 64'hFFFF_FFFF);
        rd(16'h1D04, v); chk("R13 code1", v, 64'hFFFF_FFFF);
        rd(16'h0408, v); chk("R13 run", v, 64'h0);
        rd(16'h0808, v); chk("R13 status", v, 64'h0);
        rd(16'h1B48, v); chk("R13 dsrc", v, 64'h0);
        chk("R13 irq", {63'd0, irq}, 64'h0);
    endtask

    task automatic t_revision();
        logic [63:0] v;
        wr(16'h1CF0, 64'h1234);
        rd(16'h1CF0, v);
        chk("R3 revision", v, (CW == 64) ? 64'h30 : 64'h21);
    endtask

    task automatic t_rw();
        logic [63:0] v;
        wr(16'h1E18, 64'h0000_1234_5678_9ABC);
        rd(16'h1E18, v); chk("R1 counter3", v, 64'h0000_1234_5678_9ABC);
        wr(16'h1E30, 64'hABCD_0000_0000_0005);
        rd(16'h1E30, v); chk("R2 upper bits", v, 64'hABCD_0000_0000_0005 & KEEP);
        rd(16'h1E28, v); chk("R1 neighbour untouched", v, 64'h0);
        wr(16'h1E18, 64'h0);
        wr(16'h1E30, 64'h0);
    endtask

    task automatic t_event();
        logic [63:0] v;
        wr(16'h1D04, 64'hFFFF_10FF);
        rd(16'h1D04, v); chk("R4 code readback", v, 64'hFFFF_10FF);
        wr(16'h1C00, 64'h20);
        wr(16'h0408, 64'h1_0000);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            evt[16] = (k % 2 == 0);
        end
        @(negedge clk);
        evt[16] = 1'b0;
        wr(16'h0408, 64'h0);
        rd(16'h1E28, v); chk("R4 counter5 count", v, 64'd5);
        rd(16'h1E20, v); chk("R4 counter4 idle", v, 64'd0);
    endtask

    task automatic t_codes();
        logic [63:0] v;
        wr(16'h1D00, 64'hFFFF_FF7F);
        wr(16'h1C00, 64'h03);
        evt = '1;
        run_for(6);
        evt = '0;
        rd(16'h1E00, v); chk("R5 clock code", v, 64'd6);
        rd(16'h1E08, v); chk("R5 idle code", v, 64'd0);
        rd(16'h1E28, v); chk("R7 disabled counter", v, 64'd5);
    endtask

    task automatic t_run_off();
        logic [63:0] v;
        wr(16'h1C00, 64'h23);
        @(negedge clk);
        evt = '1;
        repeat (5) @(negedge clk);
        evt = '0;
        rd(16'h1E00, v); chk("R6 stopped counter0", v, 64'd6);
        rd(16'h1E28, v); chk("R6 stopped counter5", v, 64'd5);
    endtask

    task automatic t_wrap();
        logic [63:0] v;
        wr(16'h1D00, 64'hFF7F_FFFF);
        wr(16'h1C00, 64'h04);
        wr(16'h1E10, KEEP - 64'd2);
        run_for(3);
        rd(16'h1E10, v); chk("R8 wrapped to zero", v, 64'd0);
        rd(16'h0808, v); chk("R8 status set", v, 64'h04);
        chk("R10 masked irq", {63'd0, irq}, 64'h0);
        wr(16'h0808, 64'h0);
        rd(16'h0808, v); chk("R8 status write ignored", v, 64'h04);
        wr(16'h0800, 64'hFB);
        #1 chk("R10 unmasked irq", {63'd0, irq}, 64'h1);
        wr(16'h080C, 64'h0);
        rd(16'h0808, v); chk("R9 zero clear", v, 64'h04);
        rd(16'h080C, v); chk("R9 clear reads zero", v, 64'h0);
        wr(16'h080C, 64'h04);
        rd(16'h0808, v); chk("R9 one clears", v, 64'h0);
        chk("R10 irq after clear", {63'd0, irq}, 64'h0);
    endtask

    task automatic t_priority();
        logic [63:0] v;
        wr(16'h0408, 64'h1_0000);
        wr(16'h1E10, 64'd100);
        wr(16'h0408, 64'h0);
        rd(16'h1E10, v); chk("R12 write beats increment", v, 64'd101);
    endtask

    task automatic t_dsrc();
        logic [63:0] v;
        wr(16'h1B48, 64'hA1B2_C3D4);
        wr(16'h1B4C, 64'h0F1E_2D3C);
        rd(16'h1B48, v); chk("R11 dsrc low", v, 64'hA1B2_C3D4);
        rd(16'h1B4C, v); chk("R11 dsrc high", v, 64'h0F1E_2D3C);
        rd(16'h1D00, v); chk("R11 codes untouched", v, 64'hFF7F_FFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_revision();
        t_rw();
        t_event();
        t_codes();
        t_run_off();
        t_wrap();
        t_priority();
        t_dsrc();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule